// File: doc/BRIEF.md
# Multi-Chain Shift Register Exerciser

This block is a test structure for upset studies on long runs of flip-flops. It holds a bank of independent serial chains that all shift one position on every core clock edge. Each chain is fed by its own 16-bit pseudo-random generator, so the bit stream entering every chain is fully known. The test equipment can therefore predict each bit that leaves a chain. A bit that arrives wrong points to a flop that was disturbed while the bit was inside the chain.

Readout runs at one quarter of the shift rate. Every fourth core cycle, the four bits at the far end of each chain are captured as one nibble. The nibbles of all chains are packed into one wide word, and a one-cycle strobe marks each new word. Because four bits leave each chain between two captures, every bit that passes through a chain appears in exactly one output word.

Top module: `srx_top`

## Requirements
- R1: A synchronous active-high `rst` clears every chain, every generator back to its seed, the phase counter, `outWord` and `outStrobe`. After `rst` is released, the output sequence restarts exactly as it ran after the first reset.
- R2: Chain k has a 16-bit generator seeded with 16'hACE1 ^ (k * 16'h1111). On each edge the chain takes in generator bit 15, and the generator becomes {g[14:0], g[15]^g[13]^g[12]^g[10]}.
- R3: Each chain is CHAIN_LEN flops long. A bit that enters on edge t reaches the last position CHAIN_LEN-1 edges later.
- R4: Number the edges after reset release from 0. `outStrobe` is high after edge t exactly when t mod 4 equals 3. It is therefore high for one cycle in every four, and the first strobe follows edge 3.
- R5: `outWord` changes only on the edge that raises `outStrobe`, and holds its value in all other cycles.
- R6: Chain k drives bits [4k+3:4k] of `outWord`. Within a nibble, bit 0 is the oldest of the four captured bits (the chain's last position) and bit 3 is the newest.
- R7: The word latched on edge c (c mod 4 = 3) carries, in nibble bit i, the stream bit that entered the chain on edge c-CHAIN_LEN+i. Positions not yet reached by the stream read 0, so the words stay all zero while the chains fill.
- R8: The chains run independently. Each nibble follows its own chain's stream, and no two nibbles carry the same sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core shift clock |
| rst | input | 1 | Synchronous reset, active high |
| outWord | output | NUM_CHAINS*NIB_W (32) | Packed nibbles, one per chain |
| outStrobe | output | 1 | One-cycle marker for a freshly latched word |

## Verification
A fault in the phase counter shows within four cycles of reset release, either as a strobe at the wrong point of the 4-cycle cadence or as a word change without a strobe. A wrong seed, tap or shift position shows in the first word that carries stream bits, roughly CHAIN_LEN cycles after reset. A swapped bit order or misplaced field shows in that same word. Because each output bit can be traced to one stream bit entering on a known edge, a single bad flop corrupts a predictable bit of a predictable word.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] SEED_BASE = 16'hACE1;
  localparam logic [LFSR_W-1:0] SEED_STEP = 16'h1111;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic capture;   // latch the tail nibbles on this edge
  } srxCtrl_t;

  function automatic logic [LFSR_W-1:0] seedOf(input int k);
    logic [LFSR_W-1:0] kv;
    kv = LFSR_W'(k);
    return SEED_BASE ^ (kv * SEED_STEP);
  endfunction

  // Fibonacci form, polynomial x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [LFSR_W-1:0] lfsrNext(input logic [LFSR_W-1:0] g);
    return {g[LFSR_W-2:0], g[15] ^ g[13] ^ g[12] ^ g[10]};
  endfunction

endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic     clk,
  input  logic     rst,
  output srxCtrl_t ctl,
  output logic     strobe
);

  localparam int PHASE_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NIB_W - 1);

  logic [PHASE_W-1:0] phaseQ;
  logic               strobeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ  <= '0;
      strobeQ <= 1'b0;
    end else begin
      phaseQ  <= (phaseQ == LAST_PHASE) ? '0 : phaseQ + 1'b1;
      strobeQ <= (phaseQ == LAST_PHASE);
    end
  end

  always_comb begin
    ctl.capture = (phaseQ == LAST_PHASE);
  end

  assign strobe = strobeQ;

endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int NUM_CHAINS = 8,
  parameter int CHAIN_LEN  = 2000,
  parameter int NIB_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  srxCtrl_t                     ctl,
  output logic [NUM_CHAINS*NIB_W-1:0]  word
);

  localparam int WORD_W = NUM_CHAINS * NIB_W;

  logic [WORD_W-1:0] tailWord;
  logic [WORD_W-1:0] wordQ;

  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
    logic [LFSR_W-1:0]    lfsrQ;
    logic [CHAIN_LEN-1:0] chainQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        lfsrQ  <= seedOf(k);
        chainQ <= '0;
      end else begin
        lfsrQ  <= lfsrNext(lfsrQ);
        chainQ <= {chainQ[CHAIN_LEN-2:0], lfsrQ[LFSR_W-1]};
      end
    end

    // nibble bit 0 is the oldest bit, taken from the chain's last position
    for (genvar i = 0; i < NIB_W; i++) begin : g_tap
      assign tailWord[k*NIB_W + i] = chainQ[CHAIN_LEN-1-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ <= '0;
    end else if (ctl.capture) begin
      wordQ <= tailWord;
    end
  end

  assign word = wordQ;

endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int NUM_CHAINS = 8,
  parameter int CHAIN_LEN  = 2000,
  parameter int NIB_W      = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [NUM_CHAINS*NIB_W-1:0] outWord,
  output logic                        outStrobe
);

  srxCtrl_t ctl;

  srx_ctrl #(
    .NIB_W(NIB_W)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .strobe(outStrobe)
  );

  srx_datapath #(
    .NUM_CHAINS(NUM_CHAINS),
    .CHAIN_LEN (CHAIN_LEN),
    .NIB_W     (NIB_W)
  ) dp_i (
    .clk (clk),
    .rst (rst),
    .ctl (ctl),
    .word(outWord)
  );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int NUM_CHAINS = 8,
  parameter int CHAIN_LEN  = 2000,
  parameter int NIB_W      = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CHAINS*NIB_W-1:0] outWord,
  input logic                        outStrobe
);

  localparam int MIR_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam int FILL_W = $clog2(CHAIN_LEN + 2) + 1;
  localparam int ZERO_LIMIT = CHAIN_LEN - NIB_W + 1;

  // edges since reset release, modulo NIB_W, and saturating fill count
  logic [MIR_W-1:0]  edgeMod;
  logic              started;
  logic [FILL_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeMod <= '0;
      started <= 1'b0;
      fillCnt <= '0;
    end else begin
      edgeMod <= (edgeMod == MIR_W'(NIB_W - 1)) ? '0 : edgeMod + 1'b1;
      started <= 1'b1;
      if (fillCnt <= FILL_W'(CHAIN_LEN)) fillCnt <= fillCnt + 1'b1;
    end
  end

  // R1: reset clears the outputs
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (outWord == '0 && !outStrobe));

  // R4: strobe follows the cadence, high exactly when NIB_W edges completed
  p_strobe_cadence_r4: assert property (@(posedge clk) disable iff (rst)
    started |-> (outStrobe == (edgeMod == '0)));

  // R4: strobe lasts one cycle
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    outStrobe |=> !outStrobe);

  // R5: the word moves only together with a strobe
  p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (outWord != $past(outWord)) |-> outStrobe);

  // R7: all zero while no stream bit has reached the captured positions
  p_fill_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(fillCnt) <= ZERO_LIMIT) |-> (outWord == '0));

endmodule

bind srx_top srx_checker #(
  .NUM_CHAINS(NUM_CHAINS),
  .CHAIN_LEN (CHAIN_LEN),
  .NIB_W     (NIB_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .outWord  (outWord),
  .outStrobe(outStrobe)
);

// File: tb/srx_top_tb_top.sv
module srx_top_tb_top;

  localparam int NC   = 8;
  localparam int LEN  = 37;
  localparam int NW   = 4;
  localparam int WW   = NC * NW;
  localparam int MAXT = 400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [WW-1:0] outWord;
  logic          outStrobe;

  int  errors = 0;
  int  checks = 0;
  logic stream [NC][MAXT];

  always #4 clk = ~clk;

  srx_top #(
    .NUM_CHAINS(NC),
    .CHAIN_LEN (LEN),
    .NIB_W     (NW)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .outWord  (outWord),
    .outStrobe(outStrobe)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: stream from the seeded generator, bit 15 enters on each edge
  task automatic buildStreams();
    for (int k = 0; k < NC; k++) begin
      logic [15:0] g;
      g = 16'hACE1 ^ (16'(k) * 16'h1111);
      for (int t = 0; t < MAXT; t++) begin
        stream[k][t] = g[15];
        g = {g[14:0], g[15] ^ g[13] ^ g[12] ^ g[10]};
      end
    end
  endtask

  // R3, R6, R7: word latched on the last capture edge c <= t
  function automatic logic [WW-1:0] expWord(input int t);
    logic [WW-1:0] w;
    int c;
    w = '0;
    if (t >= NW - 1) begin
      c = ((t + 1) / NW) * NW - 1;
      for (int k = 0; k < NC; k++)
        for (int i = 0; i < NW; i++) begin
          int idx;
          idx = c - LEN + i;
          w[k*NW + i] = (idx >= 0) ? stream[k][idx] : 1'b0;
        end
    end
    return w;
  endfunction

  task automatic runFrom(input int cycles);
    for (int t = 0; t < cycles; t++) begin
      logic [WW-1:0] e;
      logic es;
      @(posedge clk);
      @(negedge clk);
      es = ((t % NW) == NW - 1);
      chk(outStrobe == es, "R4 strobe cadence", WW'(outStrobe), WW'(es));
      e = expWord(t);
      for (int k = 0; k < NC; k++)
        chk(outWord[k*NW +: NW] == e[k*NW +: NW],
            $sformatf("R2,R3,R5,R6,R7,R8 chain %0d t=%0d", k, t),
            WW'(outWord[k*NW +: NW]), WW'(e[k*NW +: NW]));
    end
  endtask

  task automatic mainSeq();
    buildStreams();
    // R8: distinct seeds give distinct streams
    begin
      int same;
      same = 0;
      for (int a = 0; a < NC; a++)
        for (int b = a + 1; b < NC; b++) begin
          int d;
          d = 0;
          for (int t = 0; t < 64; t++) if (stream[a][t] != stream[b][t]) d++;
          if (d == 0) same++;
        end
      chk(same == 0, "R8 distinct streams", WW'(same), '0);
    end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outWord == '0, "R1 reset word", outWord, '0);
    chk(!outStrobe, "R1 reset strobe", WW'(outStrobe), '0);
    rst = 1'b0;
    runFrom(151);
    // mid-run reset at an unaligned phase
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(outWord == '0, "R1 mid-run reset word", outWord, '0);
    chk(!outStrobe, "R1 mid-run reset strobe", WW'(outStrobe), '0);
    rst = 1'b0;
    runFrom(140);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule